// File: doc/BRIEF.md
# Byte-Oriented File-Register Execute Unit

This block is the execute stage of an 8-bit core in which every data-memory byte is an operand register. Each cycle it takes one decoded instruction: an operation code, a destination bit and a register address. It reads that register through an external combinational read port and uses the working register held inside the block. It then writes the result to the working register or back to the addressed register through an external write port, and raises a skip request for the sequencer when the operation's condition is met.

The unit holds three pieces of state: the working register, a five-bit status word and a 16-bit product pair. The write strobe, write address, write data and the skip request are combinational in the cycle of the instruction. The state is updated on the following rising clock edge. One register-to-register move reads the first address and writes a second address that the instruction supplies.

Top module: `fr_exec_unit`

## Requirements
- R1: After reset is asserted, `wreg_o`, `status_o` and `prod_o` are zero. While `valid_i` is low, `rf_we_o` and `skip_o` are low.
- R2: Destination bit 0 updates the working register with the result and leaves `rf_we_o` low. Destination bit 1 raises `rf_we_o` with `rf_waddr_o = faddr_i` and leaves the working register unchanged. Clear, set, negate and store-working-register always write the file register. A file write never changes `wreg_o`.
- R3: `op_i` carries the ordinal of the package enumeration `fr_op_e`, numbered from 0 in its declared order. Add, add-with-carry, f−W, f−W−!C and W−f−!C produce an 8-bit result. They update `status_o = {N,OV,Z,DC,C}` (bit 4 down to bit 0) as follows: C is the carry out (not-borrow), DC is the carry out of bit 3, OV is the signed overflow, Z means a zero result and N is bit 7.
- R4: AND, inclusive OR and exclusive OR update only Z and N. C, DC and OV keep their values.
- R5: Increment, decrement and negate update all five flags by the same rules as R3. Complement, clear, set and move-to-W update only Z and N. Nibble swap changes no flag.
- R6: Rotate-left and rotate-right through carry shift the old C in and the shifted-out bit into C, and update Z and N. The rotates without carry wrap the end bit around and update Z and N only.
- R7: The compare operations raise `skip_o` when the register is equal to, unsigned greater than, or unsigned less than W. They write nothing and change no flag.
- R8: The test operation raises `skip_o` when the register is zero. It writes nothing and changes no flag.
- R9: The skipping increment and decrement write their result like any operation. They skip on a zero result or on a non-zero result, depending on the variant, and change no flag.
- R10: The register-to-register move writes the byte read at `faddr_i` to `dst_addr_i`, whatever the destination bit is. It changes no flag and leaves W unchanged.
- R11: Multiply loads the unsigned 8x8 product of the register and W into `prod_o`. It writes no register and leaves the flags unchanged.
- R12: A cycle with `valid_i` low writes nothing, raises no skip and leaves W, the flags and the product unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 5 | Operation code (`fr_op_e`) |
| dest_i | input | 1 | 0: working register, 1: file register |
| faddr_i | input | AW | Operand register address |
| dst_addr_i | input | AW | Target address of the register-to-register move |
| rf_raddr_o | output | AW | Register file read address |
| rf_rdata_i | input | DW | Register file read data |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | AW | Register file write address |
| rf_wdata_o | output | DW | Register file write data |
| wreg_o | output | DW | Working register |
| status_o | output | 5 | {N,OV,Z,DC,C} |
| prod_o | output | 2*DW | Product high:low |
| skip_o | output | 1 | Skip the next instruction |

## Verification
A wrong working-register or carry value shows up one cycle later, either directly on `wreg_o`/`status_o` or through the write data and skip request of the next instruction that depends on it. The bench therefore chains instructions so that each result feeds the next one, and compares the same-cycle write port and skip request as well as the registered state after each edge. Flag-preservation cases confirm that bits outside each operation's mask hold their previous values.

// File: rtl/fr_pkg.sv
`timescale 1ns/1ps
package fr_pkg;
  typedef enum logic [4:0] {
    OP_ADD, OP_ADDC, OP_SUBWF, OP_SUBWFB, OP_SUBFWB,
    OP_AND, OP_IOR, OP_XOR,
    OP_INC, OP_DEC, OP_COM, OP_NEG, OP_CLR, OP_SET, OP_SWAP,
    OP_MOVF, OP_MOVWF, OP_MOVFF, OP_MUL,
    OP_RLC, OP_RLN, OP_RRC, OP_RRN,
    OP_CPSEQ, OP_CPSGT, OP_CPSLT, OP_TST,
    OP_INCSZ, OP_INCSNZ, OP_DECSZ, OP_DECSNZ
  } fr_op_e;

  localparam int FLG_W  = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;

  localparam logic [FLG_W-1:0] MSK_ALL = 5'b11111;
  localparam logic [FLG_W-1:0] MSK_ZN  = 5'b10100;
  localparam logic [FLG_W-1:0] MSK_CZN = 5'b10101;
endpackage

// File: rtl/fr_alu.sv
`timescale 1ns/1ps
module fr_alu
  import fr_pkg::*;
#(
  parameter int DW = 8
) (
  input  fr_op_e            op_i,
  input  logic [DW-1:0]     f_i,
  input  logic [DW-1:0]     w_i,
  input  logic              c_i,
  output logic [DW-1:0]     res_o,
  output logic [FLG_W-1:0]  flg_o,
  output logic [FLG_W-1:0]  msk_o,
  output logic [2*DW-1:0]   prod_o
);
  localparam int MSB = DW - 1;
  localparam int NIB = 4;
  localparam int HLF = DW / 2;

  logic [DW-1:0] add_a, add_b;
  logic          add_ci;
  logic [DW:0]   sum;
  logic [NIB:0]  half;
  logic          ov;
  logic          c_n;

  // shared adder operand steering
  always_comb begin
    add_a  = f_i;
    add_b  = '0;
    add_ci = 1'b0;
    case (op_i)
      OP_ADD:    add_b = w_i;
      OP_ADDC:   begin add_b = w_i;  add_ci = c_i;  end
      OP_SUBWF:  begin add_b = ~w_i; add_ci = 1'b1; end
      OP_SUBWFB: begin add_b = ~w_i; add_ci = c_i;  end
      OP_SUBFWB: begin add_a = w_i; add_b = ~f_i; add_ci = c_i; end
      OP_INC, OP_INCSZ, OP_INCSNZ: add_ci = 1'b1;
      OP_DEC, OP_DECSZ, OP_DECSNZ: add_b  = '1;
      OP_NEG:    begin add_a = '0; add_b = ~f_i; add_ci = 1'b1; end
      default: ;
    endcase
  end

  assign sum    = {1'b0, add_a} + {1'b0, add_b} + {{DW{1'b0}}, add_ci};
  assign half   = {1'b0, add_a[NIB-1:0]} + {1'b0, add_b[NIB-1:0]} + {{NIB{1'b0}}, add_ci};
  assign ov     = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);
  assign prod_o = {{DW{1'b0}}, f_i} * {{DW{1'b0}}, w_i};

  always_comb begin
    res_o = sum[DW-1:0];
    c_n   = sum[DW];
    msk_o = '0;
    case (op_i)
      OP_ADD, OP_ADDC, OP_SUBWF, OP_SUBWFB, OP_SUBFWB,
      OP_INC, OP_DEC, OP_NEG:                 msk_o = MSK_ALL;
      OP_INCSZ, OP_INCSNZ, OP_DECSZ, OP_DECSNZ: ;
      OP_AND:   begin res_o = f_i & w_i; msk_o = MSK_ZN; end
      OP_IOR:   begin res_o = f_i | w_i; msk_o = MSK_ZN; end
      OP_XOR:   begin res_o = f_i ^ w_i; msk_o = MSK_ZN; end
      OP_COM:   begin res_o = ~f_i;      msk_o = MSK_ZN; end
      OP_CLR:   begin res_o = '0;        msk_o = MSK_ZN; end
      OP_SET:   begin res_o = '1;        msk_o = MSK_ZN; end
      OP_SWAP:  res_o = {f_i[HLF-1:0], f_i[DW-1:HLF]};
      OP_MOVF:  begin res_o = f_i;       msk_o = MSK_ZN; end
      OP_MOVWF: res_o = w_i;
      OP_RLC:   begin res_o = {f_i[DW-2:0], c_i};     c_n = f_i[MSB]; msk_o = MSK_CZN; end
      OP_RLN:   begin res_o = {f_i[DW-2:0], f_i[MSB]}; msk_o = MSK_ZN; end
      OP_RRC:   begin res_o = {c_i, f_i[DW-1:1]};     c_n = f_i[0];   msk_o = MSK_CZN; end
      OP_RRN:   begin res_o = {f_i[0], f_i[DW-1:1]};  msk_o = MSK_ZN; end
      default:  res_o = f_i;  // move-ff, multiply, compares, test
    endcase
    flg_o         = '0;
    flg_o[FLG_C]  = c_n;
    flg_o[FLG_DC] = half[NIB];
    flg_o[FLG_OV] = ov;
    flg_o[FLG_Z]  = (res_o == '0);
    flg_o[FLG_N]  = res_o[MSB];
  end
endmodule

// File: rtl/fr_skip.sv
`timescale 1ns/1ps
module fr_skip
  import fr_pkg::*;
#(
  parameter int DW = 8
) (
  input  fr_op_e        op_i,
  input  logic [DW-1:0] f_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] res_i,
  output logic          skip_o
);
  always_comb begin
    case (op_i)
      OP_CPSEQ:             skip_o = (f_i == w_i);
      OP_CPSGT:             skip_o = (f_i >  w_i);
      OP_CPSLT:             skip_o = (f_i <  w_i);
      OP_TST:               skip_o = (f_i == '0);
      OP_INCSZ,  OP_DECSZ:  skip_o = (res_i == '0);
      OP_INCSNZ, OP_DECSNZ: skip_o = (res_i != '0);
      default:              skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fr_exec_unit.sv
`timescale 1ns/1ps
module fr_exec_unit
  import fr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [4:0]      op_i,
  input  logic            dest_i,
  input  logic [AW-1:0]   faddr_i,
  input  logic [AW-1:0]   dst_addr_i,
  output logic [AW-1:0]   rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [AW-1:0]   rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic [DW-1:0]   wreg_o,
  output logic [FLG_W-1:0] status_o,
  output logic [2*DW-1:0] prod_o,
  output logic            skip_o
);
  localparam int PW = 2 * DW;

  fr_op_e             op;
  logic [DW-1:0]      w_q, res;
  logic [FLG_W-1:0]   st_q, flg, msk;
  logic [PW-1:0]      prod_q, prod;
  logic               skip_raw, to_file, to_w;

  assign op = fr_op_e'(op_i);

  fr_alu #(.DW(DW)) u_alu (
    .op_i (op), .f_i(rf_rdata_i), .w_i(w_q), .c_i(st_q[FLG_C]),
    .res_o(res), .flg_o(flg), .msk_o(msk), .prod_o(prod)
  );

  fr_skip #(.DW(DW)) u_skip (
    .op_i(op), .f_i(rf_rdata_i), .w_i(w_q), .res_i(res), .skip_o(skip_raw)
  );

  // destination steering
  always_comb begin
    case (op)
      OP_CLR, OP_SET, OP_NEG, OP_MOVWF, OP_MOVFF: begin to_file = 1'b1; to_w = 1'b0; end
      OP_MUL, OP_CPSEQ, OP_CPSGT, OP_CPSLT, OP_TST: begin to_file = 1'b0; to_w = 1'b0; end
      default: begin to_file = dest_i; to_w = ~dest_i; end
    endcase
  end

  assign rf_raddr_o = faddr_i;
  assign rf_we_o    = valid_i & to_file;
  assign rf_waddr_o = (op == OP_MOVFF) ? dst_addr_i : faddr_i;
  assign rf_wdata_o = res;
  assign skip_o     = valid_i & skip_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      st_q   <= '0;
      prod_q <= '0;
    end else if (valid_i) begin
      if (to_w) w_q <= res;
      st_q <= (st_q & ~msk) | (flg & msk);
      if (op == OP_MUL) prod_q <= prod;
    end
  end

  assign wreg_o   = w_q;
  assign status_o = st_q;
  assign prod_o   = prod_q;

  p_file_write_keeps_w_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> $stable(wreg_o));

  p_w_dest_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dest_i && op_i == OP_ADD) |-> !rf_we_o);

  p_logic_keeps_cdo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_AND || op_i == OP_IOR || op_i == OP_XOR))
      |=> ($stable(status_o[FLG_C]) && $stable(status_o[FLG_DC]) && $stable(status_o[FLG_OV])));

  p_cmp_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_CPSEQ || op_i == OP_CPSGT || op_i == OP_CPSLT)) |-> !rf_we_o);

  p_cmp_keeps_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_CPSEQ || op_i == OP_CPSGT || op_i == OP_CPSLT || op_i == OP_TST))
      |=> $stable(status_o));

  p_incsz_skip_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_INCSZ && skip_o) |-> (rf_wdata_o == '0));

  p_mul_keeps_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_MUL) |=> $stable(status_o));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!rf_we_o && !skip_o));

  p_idle_holds_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(wreg_o) && $stable(status_o) && $stable(prod_o)));
endmodule

// File: tb/fr_exec_unit_tb_top.sv
`timescale 1ns/1ps
module fr_exec_unit_tb_top;
  import fr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  fr_op_e      op_s;
  logic        dest;
  logic [7:0]  faddr, daddr, rdata;
  logic [7:0]  raddr, waddr, wdata, wreg;
  logic        we, skip;
  logic [4:0]  status;
  logic [15:0] prod;

  always #2.5 clk = ~clk;

  fr_exec_unit #(.DW(8), .AW(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op_s), .dest_i(dest),
    .faddr_i(faddr), .dst_addr_i(daddr), .rf_raddr_o(raddr), .rf_rdata_i(rdata),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata), .wreg_o(wreg),
    .status_o(status), .prod_o(prod), .skip_o(skip)
  );

  typedef struct {
    logic        we;
    logic [7:0]  waddr;
    logic [7:0]  wdata;
    logic        skip;
    logic [7:0]  w;
    logic [4:0]  st;
    logic [15:0] prod;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          n_run = 0, n_fail = 0;
  logic [7:0]  m_w  = '0;
  logic [4:0]  m_st = '0;
  logic [15:0] m_prod = '0;

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: apply one instruction and push the expected result
  task automatic issue(fr_op_e op, logic d, logic [7:0] fa, logic [7:0] da,
                       logic [7:0] fv, string req);
    exp_t e;
    int a, b, ci, s, sa, sb, ss;
    logic [7:0] r;
    logic c, dc, ov, arith, wf, ww, sk;
    logic [4:0] msk, nf;
    a = fv; b = 0; ci = 0; arith = 1'b0; r = fv; msk = '0;
    c = 1'b0; dc = 1'b0; ov = 1'b0; sk = 1'b0;
    case (op)
      OP_ADD:    begin b = m_w; arith = 1; msk = 5'h1F; end
      OP_ADDC:   begin b = m_w; ci = m_st[0]; arith = 1; msk = 5'h1F; end
      OP_SUBWF:  begin b = 255 - m_w; ci = 1; arith = 1; msk = 5'h1F; end
      OP_SUBWFB: begin b = 255 - m_w; ci = m_st[0]; arith = 1; msk = 5'h1F; end
      OP_SUBFWB: begin a = m_w; b = 255 - fv; ci = m_st[0]; arith = 1; msk = 5'h1F; end
      OP_INC:    begin ci = 1; arith = 1; msk = 5'h1F; end
      OP_DEC:    begin b = 255; arith = 1; msk = 5'h1F; end
      OP_NEG:    begin a = 0; b = 255 - fv; ci = 1; arith = 1; msk = 5'h1F; end
      OP_INCSZ:  begin ci = 1; arith = 1; end
      OP_INCSNZ: begin ci = 1; arith = 1; end
      OP_DECSZ:  begin b = 255; arith = 1; end
      OP_DECSNZ: begin b = 255; arith = 1; end
      OP_AND:    begin r = fv & m_w; msk = 5'h14; end
      OP_IOR:    begin r = fv | m_w; msk = 5'h14; end
      OP_XOR:    begin r = fv ^ m_w; msk = 5'h14; end
      OP_COM:    begin r = ~fv; msk = 5'h14; end
      OP_CLR:    begin r = 8'h00; msk = 5'h14; end
      OP_SET:    begin r = 8'hFF; msk = 5'h14; end
      OP_SWAP:   r = {fv[3:0], fv[7:4]};
      OP_MOVF:   msk = 5'h14;
      OP_MOVWF:  r = m_w;
      OP_RLC:    begin r = {fv[6:0], m_st[0]}; c = fv[7]; msk = 5'h15; end
      OP_RLN:    begin r = {fv[6:0], fv[7]}; msk = 5'h14; end
      OP_RRC:    begin r = {m_st[0], fv[7:1]}; c = fv[0]; msk = 5'h15; end
      OP_RRN:    begin r = {fv[0], fv[7:1]}; msk = 5'h14; end
      default: ;
    endcase
    if (arith) begin
      s  = a + b + ci;
      r  = s[7:0];
      c  = (s > 255);
      dc = ((a % 16) + (b % 16) + ci) > 15;
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      ss = sa + sb + ci;
      ov = (ss > 127) || (ss < -128);
    end
    case (op)
      OP_CPSEQ:  sk = (fv == m_w);
      OP_CPSGT:  sk = (fv > m_w);
      OP_CPSLT:  sk = (fv < m_w);
      OP_TST:    sk = (fv == 0);
      OP_INCSZ, OP_DECSZ:   sk = (r == 0);
      OP_INCSNZ, OP_DECSNZ: sk = (r != 0);
      default: ;
    endcase
    case (op)
      OP_CLR, OP_SET, OP_NEG, OP_MOVWF, OP_MOVFF: begin wf = 1; ww = 0; end
      OP_MUL, OP_CPSEQ, OP_CPSGT, OP_CPSLT, OP_TST: begin wf = 0; ww = 0; end
      default: begin wf = d; ww = !d; end
    endcase
    nf = {r[7], ov, (r == 0), dc, c};
    if (op == OP_MUL) m_prod = fv * m_w;
    m_st = (m_st & ~msk) | (nf & msk);
    e.we    = wf;
    e.waddr = (op == OP_MOVFF) ? da : fa;
    e.wdata = r;
    e.skip  = sk;
    if (ww) m_w = r;
    e.w     = m_w;
    e.st    = m_st;
    e.prod  = m_prod;
    e.req   = req;
    @(negedge clk);
    valid = 1'b1; op_s = op; dest = d; faddr = fa; daddr = da; rdata = fv;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    exp_t e;
    e.we = 0; e.waddr = 0; e.wdata = 0; e.skip = 0;
    e.w = m_w; e.st = m_st; e.prod = m_prod; e.req = "R12";
    @(negedge clk);
    valid = 1'b0; op_s = OP_INCSZ; dest = 1'b1; rdata = 8'hFF; faddr = 8'h44;
    sb_q.push_back(e);
  endtask

  // monitor: same-cycle port results, then registered state one cycle later
  initial begin
    exp_t cur, prv;
    logic have = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (have) begin
        check(prv.req, "wreg",   wreg,   prv.w);
        check(prv.req, "status", status, prv.st);
        check(prv.req, "prod",   prod,   prv.prod);
        have = 1'b0;
      end
      if (sb_q.size() > 0) begin
        cur = sb_q.pop_front();
        check(cur.req, "we", we, cur.we);
        if (cur.we) begin
          check(cur.req, "waddr", waddr, cur.waddr);
          check(cur.req, "wdata", wdata, cur.wdata);
        end
        check(cur.req, "skip", skip, cur.skip);
        prv  = cur;
        have = 1'b1;
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; op_s = OP_ADD; dest = 1'b0;
    faddr = '0; daddr = '0; rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "wreg",   wreg,   0);
    check("R1", "status", status, 0);
    check("R1", "prod",   prod,   0);
    check("R1", "we",     we,     0);
    check("R1", "skip",   skip,   0);
    @(negedge clk); rst_n = 1'b1;

    issue(OP_MOVF,  0, 8'h01, 8'h00, 8'h3C, "R2");
    issue(OP_MOVWF, 0, 8'h10, 8'h00, 8'h00, "R2");
    issue(OP_ADD,   1, 8'h05, 8'h00, 8'hC4, "R3");
    issue(OP_ADDC,  0, 8'h06, 8'h00, 8'h01, "R3");
    issue(OP_SUBWF, 0, 8'h07, 8'h00, 8'h10, "R3");
    issue(OP_SUBWFB,1, 8'h08, 8'h00, 8'h50, "R3");
    issue(OP_SUBFWB,0, 8'h09, 8'h00, 8'h20, "R3");
    issue(OP_MOVF,  0, 8'h01, 8'h00, 8'h40, "R2");
    issue(OP_ADD,   1, 8'h0A, 8'h00, 8'h7F, "R3");
    issue(OP_MOVF,  0, 8'h01, 8'h00, 8'h0F, "R2");
    issue(OP_AND,   0, 8'h0B, 8'h00, 8'hF0, "R4");
    issue(OP_MOVF,  0, 8'h01, 8'h00, 8'hA5, "R2");
    issue(OP_IOR,   1, 8'h0C, 8'h00, 8'h5A, "R4");
    issue(OP_XOR,   1, 8'h0D, 8'h00, 8'hA5, "R4");
    issue(OP_INC,   1, 8'h20, 8'h00, 8'hFF, "R5");
    issue(OP_DEC,   1, 8'h21, 8'h00, 8'h80, "R5");
    issue(OP_DEC,   1, 8'h22, 8'h00, 8'h00, "R5");
    issue(OP_COM,   1, 8'h23, 8'h00, 8'h0F, "R5");
    issue(OP_NEG,   0, 8'h24, 8'h00, 8'h01, "R5");
    issue(OP_CLR,   0, 8'h25, 8'h00, 8'h77, "R5");
    issue(OP_SET,   0, 8'h26, 8'h00, 8'h00, "R5");
    issue(OP_SWAP,  1, 8'h27, 8'h00, 8'h3C, "R5");
    issue(OP_RLC,   1, 8'h30, 8'h00, 8'h81, "R6");
    issue(OP_RLC,   1, 8'h30, 8'h00, 8'h40, "R6");
    issue(OP_RLN,   1, 8'h31, 8'h00, 8'h81, "R6");
    issue(OP_RRC,   1, 8'h32, 8'h00, 8'h01, "R6");
    issue(OP_RRN,   0, 8'h33, 8'h00, 8'h01, "R6");
    issue(OP_MOVF,  0, 8'h01, 8'h00, 8'h7F, "R2");
    issue(OP_CPSEQ, 1, 8'h40, 8'h00, 8'h7F, "R7");
    issue(OP_CPSGT, 1, 8'h40, 8'h00, 8'h80, "R7");
    issue(OP_CPSLT, 1, 8'h40, 8'h00, 8'h80, "R7");
    issue(OP_CPSLT, 1, 8'h40, 8'h00, 8'h10, "R7");
    issue(OP_CPSGT, 1, 8'h40, 8'h00, 8'h10, "R7");
    issue(OP_CPSEQ, 1, 8'h40, 8'h00, 8'h7E, "R7");
    issue(OP_TST,   1, 8'h41, 8'h00, 8'h00, "R8");
    issue(OP_TST,   1, 8'h41, 8'h00, 8'h01, "R8");
    issue(OP_INCSZ, 1, 8'h50, 8'h00, 8'hFF, "R9");
    issue(OP_INCSNZ,0, 8'h51, 8'h00, 8'hFF, "R9");
    issue(OP_DECSZ, 1, 8'h52, 8'h00, 8'h01, "R9");
    issue(OP_DECSNZ,1, 8'h53, 8'h00, 8'h01, "R9");
    issue(OP_DECSNZ,1, 8'h54, 8'h00, 8'h05, "R9");
    issue(OP_MOVFF, 0, 8'h12, 8'h34, 8'h9C, "R10");
    issue(OP_MOVF,  0, 8'h01, 8'h00, 8'hFF, "R2");
    issue(OP_MUL,   1, 8'h60, 8'h00, 8'hFF, "R11");
    issue(OP_MOVF,  0, 8'h01, 8'h00, 8'h0D, "R2");
    issue(OP_MUL,   0, 8'h61, 8'h00, 8'h0C, "R11");
    idle();
    idle();
    idle();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule